// File: doc/BRIEF.md
# Masked-Write General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port that sits on a 32-bit memory-mapped register bus. Each pin has an output-enable bit and an output latch. Software turns pins into outputs or inputs through two strobe registers. Writing a 1 to a bit acts on that pin, and writing a 0 leaves the pin alone. Output values go into two half-word registers, one for pins 0 to 15 and one for pins 16 to 31. The upper half of each write is a per-bit mask, so a single pin can change without a read-modify-write sequence. The output latch is kept while a pin is an input. Software can therefore load the value first and only then turn the driver on.

The input pins pass through a two-flop synchronizer, and a level register returns the synchronized value. A small bus state machine accepts one request per idle cycle. It has two states:

- ST_IDLE: `bus_ready` is high. A read accepted here moves the machine to ST_RESP. A write is applied at the accept edge and the machine stays in ST_IDLE.
- ST_RESP: `bus_rvalid` is high for one cycle and carries the read data. `bus_ready` is low. The machine always returns to ST_IDLE on the next edge.

Register map (byte offsets, word aligned):

| Offset | Write | Read |
| --- | --- | --- |
| 0x00 | set-output strobe | direction vector |
| 0x04 | set-input strobe | direction vector |
| 0x08 | pins 0 to 15: mask in bits 31:16, values in bits 15:0 | latch values in 15:0, upper bits zero |
| 0x0C | pins 16 to 31: same layout | latch values in 15:0, upper bits zero |
| 0x10 | no effect | synchronized pin levels |

Top module: `gpio_port`

## Requirements
- R1: Reset (`rst_n` low) makes every pin an input and clears every output latch. In reset, `pin_oe` = 0, `pin_out` = 0 and `bus_rvalid` = 0, and a later read of offset 0x00 returns 0.
- R2: A write to offset 0x00 sets `pin_oe[i]` for every bit i where `bus_wdata[i]` is 1 and leaves the other bits unchanged. The change is visible after the accepting edge.
- R3: A write to offset 0x04 clears `pin_oe[i]` for every bit i where `bus_wdata[i]` is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x08 sets `pin_out[i]` = `bus_wdata[i]` for i in 0..15 only where mask bit `bus_wdata[16+i]` is 1. The other bits of `pin_out` are unchanged.
- R5: A write to offset 0x0C sets `pin_out[16+i]` = `bus_wdata[i]` only where `bus_wdata[16+i]` is 1. The other bits of `pin_out` are unchanged.
- R6: The output latch is independent of direction. A value written while a pin is an input stays on `pin_out`. Changing direction never alters `pin_out`.
- R7: A read of offset 0x10 returns the pin levels through a two-stage synchronizer. Take edge 0 as the first clock edge after `pin_in` changes. A read accepted on edge 0 or edge 1 returns the previous level, and a read accepted on edge 2 returns the new level.
- R8: Reads of offsets 0x00 and 0x04 return the direction vector (1 = output). Reads of 0x08 and 0x0C return the 16 latch values of their half in bits 15:0, with zeros in bits 31:16.
- R9: `bus_ready` is high in ST_IDLE.
  - A request is accepted on an edge where `bus_valid` and `bus_ready` are both high.
  - A read accepted on an edge raises `bus_rvalid` with its data for exactly the following cycle, and `bus_ready` is low in that cycle.
  - A write never raises `bus_rvalid`.
- R10: An address is unmapped if its word index is above 4 or its low two bits are non-zero. Writes to an unmapped address change neither `pin_oe` nor `pin_out`, and reads of an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request can be accepted this cycle |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| pin_in | input | NUM_PINS (32) | Pin levels from the pads |
| pin_oe | output | NUM_PINS (32) | Per-pin output enable |
| pin_out | output | NUM_PINS (32) | Per-pin output value |

## Verification
The bench builds the port with its defaults: NUM_PINS = 32, SYNC_STAGES = 2 and ADDR_W = 8. With these values each half register has the full 16-bit mask and value fields, so the mask split at bit 16 is exercised at both ends of each half. The two-stage synchronizer gives an exact three-edge boundary that the bench probes on each side. An 8-bit address leaves room for unmapped and misaligned offsets whose writes are shown to have no effect at the pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int BUS_W = 32;

    // Word indices of the register map (byte offset / 4).
    localparam logic [2:0] IDX_SET_OUT = 3'd0;
    localparam logic [2:0] IDX_SET_IN  = 3'd1;
    localparam logic [2:0] IDX_OUT_LO  = 3'd2;
    localparam logic [2:0] IDX_OUT_HI  = 3'd3;
    localparam logic [2:0] IDX_LEVEL   = 3'd4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] rd_src,
    output logic             ready,
    output logic             acc_wr,
    output logic             rvalid,
    output logic [BUS_W-1:0] rdata
);

    bus_state_e state_q, state_d;
    logic       acc_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid && !req_write) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready  = 1'b0;
        rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE: ready  = 1'b1;
            ST_RESP: rvalid = 1'b1;
            default: ;
        endcase
        acc_wr = ready && req_valid && req_write;
        acc_rd = ready && req_valid && !req_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (acc_rd) rdata <= rd_src;
    end

endmodule

// File: rtl/gpio_dir_ctl.sv
module gpio_dir_ctl #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] bits,
    output logic [W-1:0] dir
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir <= '0;
        else if (set_we) dir <= dir | bits;
        else if (clr_we) dir <= dir & ~bits;
    end

endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] val,
    output logic [W-1:0] latch
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  latch <= '0;
        else if (we) latch <= (latch & ~mask) | (val & mask);
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= (g == 0) ? din : stg[(g == 0) ? 0 : g - 1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic                bus_ready,
    output logic                bus_rvalid,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out
);

    localparam int HALF_W = NUM_PINS / 2;

    logic               acc_wr;
    logic               mapped;
    logic [2:0]         idx;
    logic [BUS_W-1:0]   rd_src;
    logic [NUM_PINS-1:0] level;
    logic [1:0]         half_we;

    // Decode: word aligned, upper address bits zero, index 0..4.
    assign idx    = bus_addr[4:2];
    assign mapped = (bus_addr[1:0] == 2'b00) &&
                    (bus_addr[ADDR_W-1:5] == '0) &&
                    (idx <= IDX_LEVEL);

    gpio_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (bus_valid),
        .req_write (bus_write),
        .rd_src    (rd_src),
        .ready     (bus_ready),
        .acc_wr    (acc_wr),
        .rvalid    (bus_rvalid),
        .rdata     (bus_rdata)
    );

    gpio_dir_ctl #(.W(NUM_PINS)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (acc_wr && mapped && idx == IDX_SET_OUT),
        .clr_we (acc_wr && mapped && idx == IDX_SET_IN),
        .bits   (bus_wdata[NUM_PINS-1:0]),
        .dir    (pin_oe)
    );

    assign half_we[0] = acc_wr && mapped && idx == IDX_OUT_LO;
    assign half_we[1] = acc_wr && mapped && idx == IDX_OUT_HI;

    for (genvar h = 0; h < 2; h++) begin : g_half
        gpio_out_half #(.W(HALF_W)) u_half (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (half_we[h]),
            .mask  (bus_wdata[HALF_W +: HALF_W]),
            .val   (bus_wdata[0 +: HALF_W]),
            .latch (pin_out[h*HALF_W +: HALF_W])
        );
    end

    gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (level)
    );

    always_comb begin
        rd_src = '0;
        if (mapped) begin
            unique case (idx)
                IDX_SET_OUT, IDX_SET_IN: rd_src = BUS_W'(pin_oe);
                IDX_OUT_LO: rd_src = BUS_W'(pin_out[0 +: HALF_W]);
                IDX_OUT_HI: rd_src = BUS_W'(pin_out[HALF_W +: HALF_W]);
                IDX_LEVEL:  rd_src = BUS_W'(level);
                default:    rd_src = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic                bus_ready,
    input logic                bus_rvalid,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_out
);

    logic wr_acc, rd_acc, wr_set, wr_clr, wr_lo, wr_hi;
    assign wr_acc = bus_valid && bus_ready && bus_write;
    assign rd_acc = bus_valid && bus_ready && !bus_write;
    assign wr_set = wr_acc && bus_addr == ADDR_W'('h00);
    assign wr_clr = wr_acc && bus_addr == ADDR_W'('h04);
    assign wr_lo  = wr_acc && bus_addr == ADDR_W'('h08);
    assign wr_hi  = wr_acc && bus_addr == ADDR_W'('h0C);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (pin_oe == '0 && pin_out == '0 && !bus_rvalid);
        end
    end

    assert_set_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> pin_oe == ($past(pin_oe) | $past(bus_wdata[NUM_PINS-1:0])));

    assert_set_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> pin_oe == ($past(pin_oe) & ~$past(bus_wdata[NUM_PINS-1:0])));

    assert_mask_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> pin_out[15:0] == (($past(pin_out[15:0]) & ~$past(bus_wdata[31:16]))
                                   | ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

    assert_mask_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> pin_out[31:16] == (($past(pin_out[31:16]) & ~$past(bus_wdata[31:16]))
                                    | ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo || wr_hi) |=> $stable(pin_out));

    assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(pin_oe));

    assert_read_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> bus_rvalid && !bus_ready);

    assert_resp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);

    assert_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !bus_rvalid);

endmodule

bind gpio_port gpio_port_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .bus_rvalid (bus_rvalid),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_oe;
    logic [31:0] pin_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_oe  = '0;
    logic [31:0] exp_out = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d,
                          output logic rv, output logic rdy);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        d = bus_rdata; rv = bus_rvalid; rdy = bus_ready;
        bus_valid = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d; logic rv, rdy;
        bus_rd(a, d, rv, rdy);
        chk(tag, d, exp);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", pin_oe, 32'h0);
        chk("R1 out in reset", pin_out, 32'h0);
        chk("R1 rvalid in reset", {31'h0, bus_rvalid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R1 dir read after reset", 8'h00, 32'h0);
    endtask

    task automatic t_set_out();
        bus_wr(8'h00, 32'h0000_00F0); exp_oe = 32'h0000_00F0;
        chk("R2 set nibble", pin_oe, exp_oe);
        bus_wr(8'h00, 32'h0001_0001); exp_oe = 32'h0001_00F1;
        chk("R2 set accumulates", pin_oe, exp_oe);
        bus_wr(8'h00, 32'h0);
        chk("R2 zero write no change", pin_oe, exp_oe);
    endtask

    task automatic t_set_in();
        bus_wr(8'h04, 32'h0000_0030); exp_oe = 32'h0001_00C1;
        chk("R3 clear bits", pin_oe, exp_oe);
        bus_wr(8'h04, 32'h0);
        chk("R3 zero write no change", pin_oe, exp_oe);
    endtask

    task automatic t_out_lo();
        bus_wr(8'h08, 32'hFFFF_A5A5); exp_out = 32'h0000_A5A5;
        chk("R4 full mask", pin_out, exp_out);
        bus_wr(8'h08, 32'h000F_0000); exp_out = 32'h0000_A5A0;
        chk("R4 partial mask", pin_out, exp_out);
        bus_wr(8'h08, 32'h0000_FFFF);
        chk("R4 empty mask", pin_out, exp_out);
    endtask

    task automatic t_out_hi();
        bus_wr(8'h0C, 32'h00FF_003C); exp_out = 32'h003C_A5A0;
        chk("R5 upper half masked", pin_out, exp_out);
    endtask

    task automatic t_hold();
        bus_wr(8'h0C, 32'h8000_8000); exp_out = 32'h803C_A5A0;
        chk("R6 latch set while input", pin_out, exp_out);
        chk("R6 pin still input", pin_oe, exp_oe);
        bus_wr(8'h00, 32'h8000_0000); exp_oe = exp_oe | 32'h8000_0000;
        chk("R6 latch kept on switch to output", pin_out, exp_out);
        bus_wr(8'h04, 32'h8000_0000); exp_oe = exp_oe & ~32'h8000_0000;
        chk("R6 latch kept on switch to input", pin_out, exp_out);
    endtask

    task automatic t_readback();
        rd_chk("R8 read 0x00", 8'h00, exp_oe);
        rd_chk("R8 read 0x04", 8'h04, exp_oe);
        rd_chk("R8 read 0x08", 8'h08, {16'h0, exp_out[15:0]});
        rd_chk("R8 read 0x0C", 8'h0C, {16'h0, exp_out[31:16]});
    endtask

    task automatic t_sync();
        pin_in = 32'h1234_5678;
        @(posedge clk); @(negedge clk);
        rd_chk("R7 read on second edge old", 8'h10, 32'h0);
        rd_chk("R7 read after sync new", 8'h10, 32'h1234_5678);
        pin_in = 32'hFFFF_0000;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd_chk("R7 read on third edge new", 8'h10, 32'hFFFF_0000);
    endtask

    task automatic t_handshake();
        logic [31:0] d; logic rv, rdy;
        chk("R9 ready idle", {31'h0, bus_ready}, 32'h1);
        bus_rd(8'h00, d, rv, rdy);
        chk("R9 rvalid after read", {31'h0, rv}, 32'h1);
        chk("R9 ready low in response", {31'h0, rdy}, 32'h0);
        chk("R9 rvalid single cycle", {31'h0, bus_rvalid}, 32'h0);
        bus_wr(8'h08, 32'h0);
        chk("R9 no rvalid on write", {31'h0, bus_rvalid}, 32'h0);
    endtask

    task automatic t_unmapped();
        bus_wr(8'h14, 32'hFFFF_FFFF);
        chk("R10 unmapped write oe", pin_oe, exp_oe);
        chk("R10 unmapped write out", pin_out, exp_out);
        bus_wr(8'h02, 32'hFFFF_FFFF);
        chk("R10 misaligned write oe", pin_oe, exp_oe);
        bus_wr(8'h89, 32'hFFFF_FFFF);
        chk("R10 high address write out", pin_out, exp_out);
        rd_chk("R10 unmapped read", 8'h18, 32'h0);
        rd_chk("R10 misaligned read", 8'h01, 32'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_set_out();
        t_set_in();
        t_out_lo();
        t_out_hi();
        t_hold();
        t_readback();
        t_sync();
        t_handshake();
        t_unmapped();
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule